// File: doc/BRIEF.md
# Clocked Serial Byte Receiver with Read-Throttled Double Buffer

This block receives 8-bit frames over a clocked serial link, least-significant bit first. In master mode it generates the shift clock itself by dividing the system clock, and drives that clock on its pin. In slave mode it takes the shift clock from the pin, passes it through a synchronizer and detects edges in the system clock domain. A configuration input selects whether bits are taken on the rising or on the falling edge of the shift clock.

Incoming bits collect in a shift register. When the eighth bit arrives, the assembled byte moves to a data register that software can read. At the same moment a level flag marking the register as full is set and a one-cycle interrupt pulse is raised. Reception is throttled by this flag. While it is set, a master stops generating clock pulses and a slave discards incoming clock edges. A read strobe clears the flag and lets the next frame start.

Top module: `srx_top`

## Requirements
- R1: After reset, `rx_full` and `rx_irq` are 0 and `rd_data` is 0.
- R2: A frame is 8 bits, received least-significant bit first: the first bit taken becomes `rd_data[0]` and the eighth becomes `rd_data[7]`.
- R3: With `cfg_master`=0 and `cfg_fall_edge`=0, `sdata_in` is sampled on rising edges of `sclk_in`. Falling edges shift nothing.
- R4: With `cfg_master`=0 and `cfg_fall_edge`=1, `sdata_in` is sampled on falling edges of `sclk_in`. Rising edges shift nothing.
- R5: When the eighth bit is taken, `rd_data` loads the byte and `rx_full` rises in the same cycle that `rx_irq` is 1. `rx_irq` is high for exactly one system clock.
- R6: While `rx_full`=1, shift-clock edges are ignored and `rd_data` holds its value. After the flag is cleared, the next frame arrives intact.
- R7: A cycle with `rd_strobe`=1 clears `rx_full` from the next cycle on. A slave clock edge that is detected in the same cycle as that read is ignored.
- R8: With `cfg_rx_en`=0, no bits are shifted and no frame completes. A partly received frame is discarded when enable drops.
- R9: In master mode, `sclk_out` idles at 0 for rising-edge mode and at 1 for falling-edge mode. Its first active transition comes DIV_HALF system clocks after `cfg_rx_en` is set, and it toggles every DIV_HALF clocks.
- R10: In master mode, `sclk_out` returns to idle after the eighth active edge and stays idle while `rx_full`=1. It resumes after a read.
- R11: In master mode, `sdata_in` is sampled on each active transition of `sclk_out`. `sclk_oe` equals `cfg_master`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: generate the shift clock; 0: take it from `sclk_in` |
| cfg_fall_edge | input | 1 | 0: rising edge is active; 1: falling edge is active |
| cfg_rx_en | input | 1 | Receive enable |
| rd_strobe | input | 1 | Data register read; clears `rx_full` |
| rd_data | output | DATA_W | Received data register |
| rx_full | output | 1 | Receive-complete flag (level) |
| rx_irq | output | 1 | One-cycle receive interrupt request |
| sclk_in | input | 1 | Shift clock from the pin (slave mode) |
| sclk_out | output | 1 | Generated shift clock (master mode) |
| sclk_oe | output | 1 | Output enable for the shift clock pin |
| sdata_in | input | 1 | Serial data from the pin |

## Verification
The coincidence of interest is a data-register read and a synchronized slave clock edge that are detected in the same system cycle. The bench drives `sclk_in` active while the flag is set. It then asserts `rd_strobe` exactly two cycles later, which is the cycle the synchronizer presents the edge. After that it sends a full byte. A correct design drops the early edge, so the scoreboard gets exactly the sent byte. If the edge were taken, the stream would shift by one bit and the interrupt would arrive one bit early, which the scoreboard reports as a mismatch.

// File: rtl/srx_pkg.sv
package srx_pkg;

   // synchronized pin pair carried through the input synchronizer
   typedef struct packed {
      logic sck;
      logic sdi;
   } srx_pin_t;

   localparam int unsigned SRX_PIN_W = $bits(srx_pin_t);

   // idle level of the shift clock: the opposite of the active edge's target
   function automatic logic srx_idle_level(input logic fall_sel);
      return fall_sel;
   endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= '0;
               else        chain[g] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= '0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_edge_pick.sv
module srx_edge_pick (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic fall_sel,
   output logic act
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   always_comb begin
      if (fall_sel) act = prev_q & ~lvl;
      else          act = lvl & ~prev_q;
   end
endmodule

// File: rtl/srx_clkgen.sv
module srx_clkgen
   import srx_pkg::*;
#(
   parameter int unsigned DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fall_sel,
   output logic sclk,
   output logic tick
);
   localparam int unsigned CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

   logic [CW-1:0] cnt_q;
   logic          sclk_q;
   logic          wrap;

   assign wrap = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (!run) begin
         cnt_q  <= '0;
         sclk_q <= srx_idle_level(fall_sel);
      end else if (wrap) begin
         cnt_q  <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // a tick marks the edge on which the clock leaves its idle level
   assign tick = run & wrap & (sclk_q == srx_idle_level(fall_sel));
   assign sclk = sclk_q;
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   input  logic         din,
   output logic         load,
   output logic [W-1:0] word
);
   localparam int unsigned CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [CW-1:0] cnt_q;
   logic [W-1:0]  sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sr_q  <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         sr_q  <= {din, sr_q[W-1:1]};
      end
   end

   assign load = tick & (cnt_q == LAST);
   assign word = {din, sr_q[W-1:1]};
endmodule

// File: rtl/srx_top.sv
module srx_top
   import srx_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_HALF    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic              cfg_fall_edge,
   input  logic              cfg_rx_en,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_full,
   output logic              rx_irq,
   input  logic              sclk_in,
   output logic              sclk_out,
   output logic              sclk_oe,
   input  logic              sdata_in
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("srx_top: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("srx_top: SYNC_STAGES must be at least 2");
      end
      if (DIV_HALF < SYNC_STAGES + 1) begin : g_bad_div
         $error("srx_top: DIV_HALF too small for the data synchronizer");
      end
   endgenerate

   srx_pin_t pin_raw, pin_s;
   logic     ext_act, m_tick, shift_tick, allow, load;
   logic [DATA_W-1:0] word;
   logic [DATA_W-1:0] buf_q;
   logic              full_q, irq_q;

   assign pin_raw.sck = sclk_in;
   assign pin_raw.sdi = sdata_in;

   srx_sync #(.STAGES(SYNC_STAGES), .W(SRX_PIN_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
   );

   srx_edge_pick u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(pin_s.sck),
      .fall_sel(cfg_fall_edge), .act(ext_act)
   );

   assign allow = cfg_rx_en & ~full_q;

   srx_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(cfg_master & allow),
      .fall_sel(cfg_fall_edge), .sclk(sclk_out), .tick(m_tick)
   );

   assign shift_tick = allow & (cfg_master ? m_tick : ext_act);

   srx_shift #(.W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(~cfg_rx_en), .tick(shift_tick),
      .din(pin_s.sdi), .load(load), .word(word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         full_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= load;
         if (load) begin
            buf_q  <= word;
            full_q <= 1'b1;
         end else if (rd_strobe) begin
            full_q <= 1'b0;
         end
      end
   end

   assign rd_data = buf_q;
   assign rx_full = full_q;
   assign rx_irq  = irq_q;
   assign sclk_oe = cfg_master;
endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_master,
   input logic              cfg_fall_edge,
   input logic              cfg_rx_en,
   input logic              rd_strobe,
   input logic [DATA_W-1:0] rd_data,
   input logic              rx_full,
   input logic              rx_irq,
   input logic              sclk_out
);
   p_irq_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> !rx_irq);

   p_irq_with_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> (rx_full && !$past(rx_full)));

   p_hold_while_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rd_strobe) |=> (rx_full && $stable(rd_data)));

   p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && rd_strobe) |=> !rx_full);

   p_disabled_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rx_en |=> !rx_irq);

   p_master_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && !cfg_rx_en) |=> (sclk_out == $past(cfg_fall_edge)));

   p_master_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && rx_full) |=> (sclk_out == $past(cfg_fall_edge)));
endmodule

bind srx_top srx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
   .cfg_fall_edge(cfg_fall_edge), .cfg_rx_en(cfg_rx_en),
   .rd_strobe(rd_strobe), .rd_data(rd_data), .rx_full(rx_full),
   .rx_irq(rx_irq), .sclk_out(sclk_out)
);

// File: tb/srx_top_tb_top.sv
`timescale 1ns/1ps
module srx_top_tb_top;
   localparam int DATA_W = 8;
   localparam int DIV_HALF = 4;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_master = 1'b0, cfg_fall_edge = 1'b0, cfg_rx_en = 1'b0;
   logic rd_strobe = 1'b0, sclk_in = 1'b0, sdata_in = 1'b0;
   logic [DATA_W-1:0] rd_data;
   logic rx_full, rx_irq, sclk_out, sclk_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [DATA_W-1:0] exp_q [$];
   bit irq_seen = 1'b0;

   always #2.5 clk = ~clk;

   srx_top #(.DATA_W(DATA_W), .DIV_HALF(DIV_HALF), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
      .cfg_fall_edge(cfg_fall_edge), .cfg_rx_en(cfg_rx_en),
      .rd_strobe(rd_strobe), .rd_data(rd_data), .rx_full(rx_full),
      .rx_irq(rx_irq), .sclk_in(sclk_in), .sclk_out(sclk_out),
      .sclk_oe(sclk_oe), .sdata_in(sdata_in)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on each interrupt pulse
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq_seen) check(!rx_irq, "R5 irq width", int'(rx_irq), 0);
         if (rx_irq) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 unexpected frame", int'(rd_data), 0);
            end else begin
               logic [DATA_W-1:0] e;
               e = exp_q.pop_front();
               check(rd_data == e, "R2 R5 byte", int'(rd_data), int'(e));
               check(rx_full, "R5 flag with irq", int'(rx_full), 1);
            end
         end
         irq_seen <= rx_irq;
      end
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic slave_bit(input logic b, input logic act);
      sdata_in = b;
      cycles(3);
      sclk_in = act;
      cycles(3);
      sclk_in = ~act;
      cycles(3);
   endtask

   task automatic slave_byte(input logic [DATA_W-1:0] b, input bit expect_it);
      if (expect_it) exp_q.push_back(b);
      for (int i = 0; i < DATA_W; i++) slave_bit(b[i], ~cfg_fall_edge);
      cycles(4);
   endtask

   task automatic do_read();
      @(negedge clk);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      check(!rx_full, "R7 read clears flag", int'(rx_full), 0);
   endtask

   task automatic master_byte(input logic [DATA_W-1:0] b);
      logic act;
      act = ~cfg_fall_edge;
      exp_q.push_back(b);
      sdata_in = b[0];
      if (rx_full) do_read();
      for (int i = 0; i < DATA_W; i++) begin
         while (sclk_out != act) @(negedge clk);
         if (i < DATA_W - 1) begin
            while (sclk_out == act) @(negedge clk);
            sdata_in = b[i+1];
         end
      end
      cycles(3);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(2);
      // R1 reset state
      check(!rx_full, "R1 flag", int'(rx_full), 0);
      check(!rx_irq, "R1 irq", int'(rx_irq), 0);
      check(rd_data == '0, "R1 data", int'(rd_data), 0);

      // R3 slave rising mode, R2 bit order
      cfg_rx_en = 1'b1;
      check(!sclk_oe, "R11 oe slave", int'(sclk_oe), 0);
      slave_byte(8'hA5, 1'b1);
      check(rx_full, "R3 frame done", int'(rx_full), 1);

      // R6 edges while full are ignored
      slave_byte(8'h3C, 1'b0);
      check(rd_data == 8'hA5, "R6 data held", int'(rd_data), 'hA5);
      check(rx_full, "R6 flag held", int'(rx_full), 1);
      do_read();
      slave_byte(8'h5A, 1'b1);

      // R7 read coincides with detected edge
      sdata_in = 1'b1;
      cycles(3);
      @(negedge clk);
      sclk_in = 1'b1;
      cycles(SYNC);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      check(!rx_full, "R7 flag cleared", int'(rx_full), 0);
      cycles(3);
      sclk_in = 1'b0;
      cycles(3);
      slave_byte(8'h24, 1'b1);

      // R4 slave falling mode
      do_read();
      cfg_fall_edge = 1'b1;
      cycles(2);
      sclk_in = 1'b1;
      cycles(4);
      slave_byte(8'hC3, 1'b1);
      check(rd_data == 8'hC3, "R4 falling byte", int'(rd_data), 'hC3);
      do_read();
      cfg_fall_edge = 1'b0;
      cycles(2);
      sclk_in = 1'b0;
      cycles(4);

      // R8 enable off: nothing shifts, partial frame discarded
      cfg_rx_en = 1'b0;
      slave_byte(8'hFF, 1'b0);
      check(!rx_full, "R8 no frame when disabled", int'(rx_full), 0);
      check(rd_data == 8'hC3, "R8 data unchanged", int'(rd_data), 'hC3);
      cfg_rx_en = 1'b1;
      for (int i = 0; i < 3; i++) slave_bit(1'b1, 1'b1);
      cfg_rx_en = 1'b0;
      cycles(2);
      cfg_rx_en = 1'b1;
      slave_byte(8'h81, 1'b1);
      check(rd_data == 8'h81, "R8 partial discarded", int'(rd_data), 'h81);

      // R9 master idle level and first edge timing
      do_read();
      cfg_rx_en = 1'b0;
      cfg_master = 1'b1;
      cycles(2);
      check(sclk_out == 1'b0, "R9 idle rising mode", int'(sclk_out), 0);
      check(sclk_oe, "R11 oe master", int'(sclk_oe), 1);
      exp_q.push_back(8'h96);
      sdata_in = 1'b0;
      cfg_rx_en = 1'b1;
      cycles(DIV_HALF - 1);
      check(sclk_out == 1'b0, "R9 before first edge", int'(sclk_out), 0);
      @(negedge clk);
      check(sclk_out == 1'b1, "R9 first edge", int'(sclk_out), 1);
      cycles(DIV_HALF - 1);
      check(sclk_out == 1'b1, "R9 half period", int'(sclk_out), 1);
      @(negedge clk);
      check(sclk_out == 1'b0, "R9 toggle", int'(sclk_out), 0);
      for (int i = 1; i < DATA_W; i++) begin
         sdata_in = (8'h96 >> i) & 1;
         while (sclk_out != 1'b1) @(negedge clk);
         if (i < DATA_W - 1) while (sclk_out == 1'b1) @(negedge clk);
      end
      cycles(3);
      check(rx_full, "R11 master frame", int'(rx_full), 1);

      // R10 clock stays idle while full
      begin
         bit moved = 1'b0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sclk_out != 1'b0) moved = 1'b1;
         end
         check(!moved, "R10 idle while full", int'(moved), 0);
      end
      master_byte(8'h3B);
      check(rd_data == 8'h3B, "R10 resumes after read", int'(rd_data), 'h3B);

      // R11 master falling mode
      do_read();
      cfg_rx_en = 1'b0;
      cfg_fall_edge = 1'b1;
      cycles(2);
      check(sclk_out == 1'b1, "R9 idle falling mode", int'(sclk_out), 1);
      cfg_rx_en = 1'b1;
      master_byte(8'hE1);
      check(rd_data == 8'hE1, "R11 falling master byte", int'(rd_data), 'hE1);

      cycles(5);
      check(exp_q.size() == 0, "R5 all frames seen", exp_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule